// File: doc/BRIEF.md
# Privilege-Aware Virtual Segment Decoder

This block sits between a load/store pipeline and a translation lookaside buffer. Each accepted request carries a 32-bit virtual address, a load/store flag and the privilege context in force: a two-bit mode field plus the exception-level and error-level status bits. Those three inputs are combined into an effective privilege. The address is then sorted into one of three outcomes. It may fall in a kernel direct window, where the physical address is formed by removing a fixed base. It may be illegal for the privilege, which raises an address error. Otherwise it is handed to the TLB.

Direct-window results and address errors come back on the pipeline response port one cycle after acceptance, and the TLB is never asked. Mapped requests are presented on the TLB port and held there until the TLB answers with a physical address or a fault. The answer is then returned on the pipeline side one cycle later. Only one request is in flight at a time.

Top module: `vseg_decoder`

## Requirements
- R1: When the exception-level bit or the error-level bit is high at acceptance, the request is decoded as kernel mode, whatever the mode field holds.
- R2: Mode field encodings are 0 kernel, 1 supervisor and 2 user. The value 3 is decoded as kernel.
- R3: In kernel mode, an address in 0x80000000..0x9FFFFFFF returns rsp_paddr = address - 0x80000000 with rsp_exc 0, one cycle after acceptance. No TLB request is raised.
- R4: In kernel mode, an address in 0xA0000000..0xBFFFFFFF returns rsp_paddr = address - 0xA0000000 with rsp_exc 0, one cycle after acceptance. No TLB request is raised.
- R5: In supervisor mode, only addresses whose bits 31:29 are 000 or 110 are legal. Any other address gives an address error.
- R6: In user mode, any address with bit 31 set gives an address error.
- R7: An address error answers one cycle after acceptance, with rsp_paddr 0 and no TLB request. rsp_exc is 1 for a load (req_store 0) and 2 for a store (req_store 1).
- R8: Every other legal address raises tlb_req_valid with tlb_vaddr and tlb_store equal to the request. The TLB request is held steady until tlb_rsp_valid or tlb_fault is seen.
- R9: The cycle after the TLB answers, rsp_valid is high. On tlb_fault the response has rsp_exc 3 and rsp_paddr 0; tlb_fault takes priority over tlb_rsp_valid. Otherwise the response has rsp_exc 0 and rsp_paddr = tlb_rsp_paddr.
- R10: req_ready is low from acceptance through the response cycle. rsp_valid is a single-cycle pulse, and req_ready is high again on the cycle after it.
- R11: While reset is high, req_ready is 1 and rsp_valid and tlb_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pipeline request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 store, 0 load |
| mode_field | input | 2 | Privilege mode field |
| exl_bit | input | 1 | Exception-level status bit |
| erl_bit | input | 1 | Error-level status bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address of the response |
| rsp_exc | output | 2 | 0 none, 1 address error load, 2 address error store, 3 TLB fault |
| tlb_req_valid | output | 1 | Lookup request to the TLB |
| tlb_vaddr | output | 32 | Address to translate |
| tlb_store | output | 1 | Access type passed to the TLB |
| tlb_rsp_valid | input | 1 | TLB translation done |
| tlb_rsp_paddr | input | 32 | TLB physical address |
| tlb_fault | input | 1 | TLB reports a fault |

## Verification
The embedded properties check several behaviours on every cycle. They check the one-cycle turnaround and address arithmetic of both kernel windows, with the exception-level override applied. They check user-mode rejection of high addresses, and the load/store coding of the error. They also check that the TLB request holds steady until answered, that the response and the TLB request never overlap, and that the block stays busy through the response cycle. Supervisor legality across all eight top-bit patterns is shown only by the bench's scenarios. So are the mode-3 fallback, the pass-through of TLB addresses, fault priority, and variable TLB latency. These scenarios compare every response against an independently computed decode.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    localparam int ADDR_W   = 32;
    localparam int WIN_BITS = 29;              // each direct window spans 2^WIN_BITS bytes
    localparam int NUM_WIN  = 2;
    localparam int TAG_W    = ADDR_W - WIN_BITS;

    typedef enum logic [1:0] {
        PRIV_KERN = 2'd0,
        PRIV_SUPV = 2'd1,
        PRIV_USER = 2'd2,
        PRIV_RSVD = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        EXC_NONE   = 2'd0,
        EXC_ADDR_LD = 2'd1,
        EXC_ADDR_ST = 2'd2,
        EXC_TLB    = 2'd3
    } exc_e;

    typedef enum logic [1:0] {
        SEG_DIRECT = 2'd0,
        SEG_MAPPED = 2'd1,
        SEG_ERROR  = 2'd2
    } seg_e;

    typedef struct packed {
        seg_e              kind;
        exc_e              exc;
        logic [ADDR_W-1:0] paddr;
    } decode_t;

    // Base of direct kernel window i (windows sit back to back from the top half).
    function automatic logic [ADDR_W-1:0] win_base(input int idx);
        logic [ADDR_W-1:0] b;
        b = {1'b1, {(ADDR_W-1){1'b0}}};
        b = b + (ADDR_W'(idx) << WIN_BITS);
        return b;
    endfunction

    function automatic exc_e addr_err_code(input logic is_store);
        return is_store ? EXC_ADDR_ST : EXC_ADDR_LD;
    endfunction

endpackage

// File: rtl/vseg_priv_resolve.sv
module vseg_priv_resolve
    import vseg_pkg::*;
(
    input  logic [1:0] mode_field,
    input  logic       exl_bit,
    input  logic       erl_bit,
    output priv_e      eff_priv
);
    always_comb begin
        if (exl_bit || erl_bit) begin
            eff_priv = PRIV_KERN;
        end else begin
            unique case (mode_field)
                2'd1:    eff_priv = PRIV_SUPV;
                2'd2:    eff_priv = PRIV_USER;
                default: eff_priv = PRIV_KERN;   // 0 and the reserved code 3
            endcase
        end
    end
endmodule

// File: rtl/vseg_classify.sv
module vseg_classify
    import vseg_pkg::*;
(
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              is_store,
    input  priv_e             eff_priv,
    output decode_t           dec
);
    logic [NUM_WIN-1:0]              win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  win_pa;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            localparam logic [ADDR_W-1:0] BASE = win_base(gi);
            assign win_hit[gi] = (vaddr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
            assign win_pa[gi]  = vaddr - BASE;
        end
    endgenerate

    logic supv_legal;
    assign supv_legal = (vaddr[ADDR_W-1 -: 3] == 3'b000) || (vaddr[ADDR_W-1 -: 3] == 3'b110);

    always_comb begin
        dec.kind  = SEG_MAPPED;
        dec.exc   = EXC_NONE;
        dec.paddr = '0;
        unique case (eff_priv)
            PRIV_SUPV: begin
                if (!supv_legal) begin
                    dec.kind = SEG_ERROR;
                    dec.exc  = addr_err_code(is_store);
                end
            end
            PRIV_USER: begin
                if (vaddr[ADDR_W-1]) begin
                    dec.kind = SEG_ERROR;
                    dec.exc  = addr_err_code(is_store);
                end
            end
            default: begin
                for (int i = 0; i < NUM_WIN; i++) begin
                    if (win_hit[i]) begin
                        dec.kind  = SEG_DIRECT;
                        dec.paddr = win_pa[i];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/vseg_ctrl.sv
module vseg_ctrl
    import vseg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_store,
    input  decode_t           dec,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output exc_e              rsp_exc,
    output logic              tlb_req_valid,
    output logic [ADDR_W-1:0] tlb_vaddr,
    output logic              tlb_store,
    input  logic              tlb_rsp_valid,
    input  logic [ADDR_W-1:0] tlb_rsp_paddr,
    input  logic              tlb_fault
);
    typedef enum logic [1:0] {ST_IDLE, ST_TLB, ST_RESP} state_e;

    state_e            state_q;
    logic [ADDR_W-1:0] va_q;
    logic              st_q;
    logic [ADDR_W-1:0] pa_q;
    exc_e              exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            st_q    <= 1'b0;
            pa_q    <= '0;
            exc_q   <= EXC_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (dec.kind == SEG_MAPPED) begin
                            state_q <= ST_TLB;
                            va_q    <= req_vaddr;
                            st_q    <= req_store;
                        end else begin
                            state_q <= ST_RESP;
                            pa_q    <= dec.paddr;
                            exc_q   <= dec.exc;
                        end
                    end
                end
                ST_TLB: begin
                    if (tlb_fault) begin
                        state_q <= ST_RESP;
                        pa_q    <= '0;
                        exc_q   <= EXC_TLB;
                    end else if (tlb_rsp_valid) begin
                        state_q <= ST_RESP;
                        pa_q    <= tlb_rsp_paddr;
                        exc_q   <= EXC_NONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_paddr     = pa_q;
    assign rsp_exc       = exc_q;
    assign tlb_req_valid = (state_q == ST_TLB);
    assign tlb_vaddr     = va_q;
    assign tlb_store     = st_q;

    // R8: an unanswered TLB request stays up with the same address and type
    p_tlb_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tlb_req_valid && !tlb_rsp_valid && !tlb_fault) |=>
            (tlb_req_valid && $stable(tlb_vaddr) && $stable(tlb_store)));

    // R9: an answered TLB request yields a response on the next cycle
    p_tlb_answer_r9: assert property (@(posedge clk) disable iff (rst)
        (tlb_req_valid && (tlb_rsp_valid || tlb_fault)) |=> rsp_valid);
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
    import vseg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_store,
    input  logic [1:0]  mode_field,
    input  logic        exl_bit,
    input  logic        erl_bit,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic [1:0]  rsp_exc,
    output logic        tlb_req_valid,
    output logic [31:0] tlb_vaddr,
    output logic        tlb_store,
    input  logic        tlb_rsp_valid,
    input  logic [31:0] tlb_rsp_paddr,
    input  logic        tlb_fault
);
    priv_e   eff_priv;
    decode_t dec;
    exc_e    exc_w;
    logic    accept;

    vseg_priv_resolve u_priv (
        .mode_field (mode_field),
        .exl_bit    (exl_bit),
        .erl_bit    (erl_bit),
        .eff_priv   (eff_priv)
    );

    vseg_classify u_cls (
        .vaddr    (req_vaddr),
        .is_store (req_store),
        .eff_priv (eff_priv),
        .dec      (dec)
    );

    vseg_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_store     (req_store),
        .dec           (dec),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_exc       (exc_w),
        .tlb_req_valid (tlb_req_valid),
        .tlb_vaddr     (tlb_vaddr),
        .tlb_store     (tlb_store),
        .tlb_rsp_valid (tlb_rsp_valid),
        .tlb_rsp_paddr (tlb_rsp_paddr),
        .tlb_fault     (tlb_fault)
    );

    assign rsp_exc = exc_w;
    assign accept  = req_valid && req_ready;

    // R1/R3: status-bit override plus lower kernel window, answered next cycle
    p_kwin0_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && (exl_bit || erl_bit) && req_vaddr[31:29] == 3'b100) |=>
            (rsp_valid && !tlb_req_valid && rsp_exc == 2'd0 &&
             rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));

    // R4: upper kernel window
    p_kwin1_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && mode_field == 2'd0 && req_vaddr[31:29] == 3'b101) |=>
            (rsp_valid && rsp_exc == 2'd0 &&
             rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));

    // R6/R7: user-mode high address gives a load or store address error
    p_user_err_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && mode_field == 2'd2 && !exl_bit && !erl_bit && req_vaddr[31]) |=>
            (rsp_valid && !tlb_req_valid && rsp_paddr == 32'd0 &&
             rsp_exc == ($past(req_store) ? 2'd2 : 2'd1)));

    // R10: busy through the response cycle, and the response is a single pulse
    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!req_ready && !tlb_req_valid));

    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R8: the TLB port is only driven while the block is busy
    p_tlb_busy_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tlb_req_valid, req_ready, rsp_valid}));
endmodule

// File: tb/sim_vseg_decoder.sv
module sim_vseg_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic [1:0]  mode_field = '0;
    logic        exl_bit = 1'b0;
    logic        erl_bit = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_exc;
    logic        tlb_req_valid;
    logic [31:0] tlb_vaddr;
    logic        tlb_store;
    logic        tlb_rsp_valid = 1'b0;
    logic [31:0] tlb_rsp_paddr = '0;
    logic        tlb_fault = 1'b0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vseg_decoder u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_store(req_store), .mode_field(mode_field),
        .exl_bit(exl_bit), .erl_bit(erl_bit), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc), .tlb_req_valid(tlb_req_valid),
        .tlb_vaddr(tlb_vaddr), .tlb_store(tlb_store), .tlb_rsp_valid(tlb_rsp_valid),
        .tlb_rsp_paddr(tlb_rsp_paddr), .tlb_fault(tlb_fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Expected decode: kind 0 direct, 1 mapped, 2 error
    function automatic int exp_kind(input logic [1:0] m, input logic x, input logic e,
                                    input logic [31:0] va);
        int pm;
        pm = (x || e || m == 2'd3) ? 0 : int'(m);
        if (pm == 0) return (va >= 32'h8000_0000 && va <= 32'hBFFF_FFFF) ? 0 : 1;
        if (pm == 1) return (va <= 32'h1FFF_FFFF || (va >= 32'hC000_0000 && va <= 32'hDFFF_FFFF)) ? 1 : 2;
        return (va >= 32'h8000_0000) ? 2 : 1;
    endfunction

    function automatic logic [31:0] exp_direct(input logic [31:0] va);
        return (va < 32'hA000_0000) ? va - 32'h8000_0000 : va - 32'hA000_0000;
    endfunction

    task automatic run_txn(input logic [1:0] m, input logic x, input logic e,
                           input logic [31:0] va, input logic st,
                           input int lat, input bit flt, input bit both,
                           input logic [31:0] tpa, input string tag);
        int k;
        k = exp_kind(m, x, e, va);
        chk(req_ready == 1'b1, {tag, " R10 ready before request"}, 32'(req_ready), 32'd1);
        mode_field = m; exl_bit = x; erl_bit = e; req_vaddr = va; req_store = st;
        req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (k != 1) begin
            chk(rsp_valid == 1'b1, {tag, " R3/R4/R7 one-cycle response"}, 32'(rsp_valid), 32'd1);
            chk(tlb_req_valid == 1'b0, {tag, " R3/R7 no TLB request"}, 32'(tlb_req_valid), 32'd0);
            if (k == 0) begin
                chk(rsp_exc == 2'd0, {tag, " R3 exc"}, 32'(rsp_exc), 32'd0);
                chk(rsp_paddr == exp_direct(va), {tag, " R4 paddr"}, rsp_paddr, exp_direct(va));
            end else begin
                chk(rsp_exc == (st ? 2'd2 : 2'd1), {tag, " R7 error code"}, 32'(rsp_exc), st ? 32'd2 : 32'd1);
                chk(rsp_paddr == 32'd0, {tag, " R7 paddr zero"}, rsp_paddr, 32'd0);
            end
            chk(req_ready == 1'b0, {tag, " R10 busy in response"}, 32'(req_ready), 32'd0);
        end else begin
            chk(rsp_valid == 1'b0, {tag, " R8 no early response"}, 32'(rsp_valid), 32'd0);
            chk(tlb_req_valid == 1'b1, {tag, " R8 TLB request"}, 32'(tlb_req_valid), 32'd1);
            chk(tlb_vaddr == va, {tag, " R8 TLB address"}, tlb_vaddr, va);
            chk(tlb_store == st, {tag, " R8 TLB type"}, 32'(tlb_store), 32'(st));
            for (int i = 0; i < lat; i++) begin
                @(posedge clk); @(negedge clk);
                chk(tlb_req_valid == 1'b1 && tlb_vaddr == va, {tag, " R8 TLB held"}, tlb_vaddr, va);
                chk(req_ready == 1'b0 && rsp_valid == 1'b0, {tag, " R10 busy waiting"}, 32'(req_ready), 32'd0);
            end
            tlb_fault = flt; tlb_rsp_valid = !flt || both; tlb_rsp_paddr = tpa;
            @(posedge clk); @(negedge clk);
            tlb_fault = 1'b0; tlb_rsp_valid = 1'b0;
            chk(rsp_valid == 1'b1 && tlb_req_valid == 1'b0, {tag, " R9 response after TLB"}, 32'(rsp_valid), 32'd1);
            chk(rsp_exc == (flt ? 2'd3 : 2'd0), {tag, " R9 exc"}, 32'(rsp_exc), flt ? 32'd3 : 32'd0);
            chk(rsp_paddr == (flt ? 32'd0 : tpa), {tag, " R9 paddr"}, rsp_paddr, flt ? 32'd0 : tpa);
        end
        @(posedge clk); @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, {tag, " R10 single pulse"}, 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(tlb_req_valid == 1'b0, "R11 reset tlb_req_valid", 32'(tlb_req_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // directed corners
        run_txn(2'd0, 0, 0, 32'h8000_0000, 0, 0, 0, 0, 0, "R3 low edge");
        run_txn(2'd0, 0, 0, 32'h9FFF_FFFF, 1, 0, 0, 0, 0, "R3 high edge");
        run_txn(2'd0, 0, 0, 32'hA000_0000, 0, 0, 0, 0, 0, "R4 low edge");
        run_txn(2'd0, 0, 0, 32'hBFFF_FFFF, 0, 0, 0, 0, 0, "R4 high edge");
        run_txn(2'd0, 0, 0, 32'hC000_0000, 0, 1, 0, 0, 32'h1234_5000, "R8 kernel mapped");
        run_txn(2'd2, 1, 0, 32'h8000_1000, 0, 0, 0, 0, 0, "R1 exl override");
        run_txn(2'd1, 0, 1, 32'hA000_2000, 1, 0, 0, 0, 0, "R1 erl override");
        run_txn(2'd3, 0, 0, 32'h9000_0040, 0, 0, 0, 0, 0, "R2 mode3 kernel");
        run_txn(2'd1, 0, 0, 32'h1FFF_FFFF, 0, 2, 0, 0, 32'h0000_7000, "R5 supv low legal");
        run_txn(2'd1, 0, 0, 32'h2000_0000, 0, 0, 0, 0, 0, "R5 supv illegal load");
        run_txn(2'd1, 0, 0, 32'hC000_0000, 1, 0, 1, 0, 0, "R5 supv 110 legal");
        run_txn(2'd1, 0, 0, 32'hE000_0000, 1, 0, 0, 0, 0, "R5 supv illegal store");
        run_txn(2'd1, 0, 0, 32'h8000_0000, 0, 0, 0, 0, 0, "R5 supv kseg");
        run_txn(2'd2, 0, 0, 32'h7FFF_FFFF, 1, 3, 0, 0, 32'hFFFF_F000, "R6 user top legal");
        run_txn(2'd2, 0, 0, 32'h8000_0000, 1, 0, 0, 0, 0, "R6 user store error");
        run_txn(2'd2, 0, 0, 32'hF000_0000, 0, 0, 0, 0, 0, "R6 user load error");
        run_txn(2'd2, 0, 0, 32'h0000_1000, 0, 1, 1, 1, 32'hDEAD_B000, "R9 fault priority");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  m;
            logic        x, e, st;
            logic [31:0] va;
            m  = 2'($urandom_range(0, 3));
            x  = ($urandom_range(0, 5) == 0);
            e  = ($urandom_range(0, 7) == 0);
            st = 1'($urandom_range(0, 1));
            va = $urandom;
            run_txn(m, x, e, va, st, $urandom_range(0, 3), ($urandom_range(0, 3) == 0),
                    1'($urandom_range(0, 1)), $urandom, "R1 R5 R6 R8 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule